// File: doc/BRIEF.md
# Variable Partition Hole Allocator

This block keeps a small table of free memory regions ("holes") for contiguous allocation and serves one request at a time. An allocation request carries a size. The block rounds that size up to whole allocation blocks and walks the table one slot per clock to choose a hole. Four policies are available: lowest-slot first fit, first fit resumed from the slot of the previous first-fit grant, smallest fitting hole, and largest hole. The granted region is taken from the low end of the chosen hole. The rest of the hole stays in the table.

A release request carries a base and a size. The block scans the whole table for holes that end exactly at the released base or start exactly at its end. It joins the released region with either neighbour, or with both. A released region that touches no neighbour takes a free slot. A request is taken when `req_valid` is high while `busy` is low. The result comes back on a single-cycle `rsp_valid` pulse, and `busy` falls on the same edge.

Top module: `hole_alloc`

## Requirements
- R1: After reset the table holds a single hole of base 0 and size 4096 (the whole space) in slot 0, with every other slot empty. `busy` and `rsp_valid` are low.
- R2: Every size is rounded up to a multiple of 16. An allocation whose rounded size is 0 fails. A release whose rounded size is 0, or whose region would pass address 4096, is refused with `rsp_ok`=0. Every granted base is a multiple of 16.
- R3: Policy 0 (first fit) examines slots from slot 0 upward and grants the first valid hole whose size is at least the rounded request. The scan stops at that slot.
- R4: Policy 3 (resumed first fit) behaves like policy 0 but starts at the slot of the most recent grant made by policy 0 or 3, and wraps past the last slot. That slot is 0 after reset.
- R5: Policy 1 (best fit) scans all slots and grants the smallest hole that fits. Holes of equal size resolve to the lower base address.
- R6: Policy 2 (worst fit) scans all slots and grants the largest hole, provided it fits. Holes of equal size resolve to the lower base address.
- R7: A grant returns the chosen hole's base. The hole's base then rises by the rounded size and its size falls by the same amount. A hole left with size 0 becomes an empty slot.
- R8: An allocation fails with `rsp_ok`=0 and `rsp_base`=0 when no single hole is large enough, even if the holes together would be. The table is then unchanged.
- R9: A release adjacent to a lower hole grows that hole. A release adjacent to an upper hole lowers that hole's base. When both neighbours exist they become one hole in the lower neighbour's slot, and the upper slot is emptied.
- R10: A release with no neighbour goes to the lowest empty slot. When no slot is empty the release is refused with `rsp_ok`=0 and the table is unchanged.
- R11: `busy` rises on the edge that accepts a request and falls on the edge that raises `rsp_valid` for one cycle. A request offered while `busy` is high is ignored. The response comes k+1 clock edges after the accepting edge, where k is the number of slots examined: the position of the hit for policies 0 and 3, and 8 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request offered; taken when `busy` is low |
| req_op | input | 1 | 0 = allocate, 1 = release |
| req_fit | input | 2 | Policy: 0 first fit, 1 best fit, 2 worst fit, 3 resumed first fit |
| req_size | input | 13 | Requested size in address units, before rounding |
| req_base | input | 12 | Base of the region being released |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_ok | output | 1 | 1 = granted or released, 0 = failed or refused |
| rsp_base | output | 12 | Granted base; 0 on failure and on release |

## Verification
A first-fit or resumed-first-fit grant at the j-th examined slot is due j+1 edges after the accepting edge. Every other allocation, every failure and every release is due 9 edges after the accepting edge. The bench samples at each negative edge after acceptance and counts the edges until the pulse appears. It compares that count, together with `rsp_ok` and `rsp_base`, against an arithmetic model of the hole table built from the requirements. `busy` is checked high one half-cycle after acceptance and low when the pulse is seen. `rsp_valid` is checked low one cycle later. Requests are also offered during the busy window; the model ignores them, so any wrongly accepted request shows up as a mismatch in later grants.

// File: rtl/hole_pkg.sv
package hole_pkg;
  typedef enum logic [1:0] {
    FIT_FIRST = 2'd0,
    FIT_BEST  = 2'd1,
    FIT_WORST = 2'd2,
    FIT_NEXT  = 2'd3
  } fit_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_COMMIT = 2'd2
  } state_e;

  localparam logic OP_ALLOC = 1'b0;
  localparam logic OP_FREE  = 1'b1;
endpackage

// File: rtl/hole_rst_sync.sv
module hole_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_sync_n = sr_q[1];
endmodule

// File: rtl/hole_table.sv
module hole_table #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 12,
  parameter int IDX_W   = 3,
  parameter int SIZE_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [ADDR_W-1:0] rd_base,
  output logic [SIZE_W-1:0] rd_size,
  input  logic              wa_en,
  input  logic [IDX_W-1:0]  wa_idx,
  input  logic              wa_vld,
  input  logic [ADDR_W-1:0] wa_base,
  input  logic [SIZE_W-1:0] wa_size,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx
);
  localparam logic [SIZE_W-1:0] MEM_SIZE = SIZE_W'(1) << ADDR_W;

  logic [ENTRIES-1:0] vld_w;
  logic [ADDR_W-1:0]  base_w [ENTRIES];
  logic [SIZE_W-1:0]  size_w [ENTRIES];

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic              v_q;
      logic [ADDR_W-1:0] b_q;
      logic [SIZE_W-1:0] s_q;
      logic              hit_a;
      logic              hit_b;

      assign hit_a = wa_en && (wa_idx == IDX_W'(g));
      assign hit_b = wb_en && (wb_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= (g == 0);
          b_q <= '0;
          s_q <= (g == 0) ? MEM_SIZE : '0;
        end else if (hit_a) begin
          v_q <= wa_vld;
          b_q <= wa_base;
          s_q <= wa_size;
        end else if (hit_b) begin
          v_q <= 1'b0;
        end
      end

      assign vld_w[g]  = v_q;
      assign base_w[g] = b_q;
      assign size_w[g] = s_q;
    end
  endgenerate

  assign rd_vld  = vld_w[rd_idx];
  assign rd_base = base_w[rd_idx];
  assign rd_size = size_w[rd_idx];
endmodule

// File: rtl/hole_fit_cmp.sv
module hole_fit_cmp
  import hole_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SIZE_W = 13,
  parameter int NEED_W = 14
) (
  input  fit_e              policy,
  input  logic              ent_vld,
  input  logic [ADDR_W-1:0] ent_base,
  input  logic [SIZE_W-1:0] ent_size,
  input  logic [NEED_W-1:0] need,
  input  logic              have_best,
  input  logic [ADDR_W-1:0] best_base,
  input  logic [SIZE_W-1:0] best_size,
  output logic              fits,
  output logic              better
);
  logic [NEED_W-1:0] ent_ext;
  logic smaller, larger, same, lower_base;

  assign ent_ext    = NEED_W'(ent_size);
  assign fits       = ent_vld && (|need) && (ent_ext >= need);
  assign smaller    = ent_size < best_size;
  assign larger     = ent_size > best_size;
  assign same       = ent_size == best_size;
  assign lower_base = ent_base < best_base;

  always_comb begin
    case (policy)
      FIT_BEST:  better = fits && (!have_best || smaller || (same && lower_base));
      FIT_WORST: better = fits && (!have_best || larger  || (same && lower_base));
      default:   better = fits && !have_best;
    endcase
  end
endmodule

// File: rtl/hole_ctrl.sv
module hole_ctrl
  import hole_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 12,
  parameter int BLK_W   = 4,
  parameter int IDX_W   = 3,
  parameter int SIZE_W  = 13,
  parameter int NEED_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [1:0]        req_fit,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [ADDR_W-1:0] req_base,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_vld,
  input  logic [ADDR_W-1:0] rd_base,
  input  logic [SIZE_W-1:0] rd_size,
  input  logic              fits,
  input  logic              better,
  output fit_e              cmp_policy,
  output logic [NEED_W-1:0] cmp_need,
  output logic              cmp_have,
  output logic [ADDR_W-1:0] cmp_bbase,
  output logic [SIZE_W-1:0] cmp_bsize,
  output logic              wa_en,
  output logic [IDX_W-1:0]  wa_idx,
  output logic              wa_vld,
  output logic [ADDR_W-1:0] wa_base,
  output logic [SIZE_W-1:0] wa_size,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [ADDR_W-1:0] rsp_base
);
  localparam logic [NEED_W-1:0] BLK_MASK = NEED_W'((1 << BLK_W) - 1);
  localparam logic [NEED_W-1:0] MEM_END  = NEED_W'(1) << ADDR_W;
  localparam logic [IDX_W-1:0]  LAST     = IDX_W'(ENTRIES - 1);

  state_e            st_q, st_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d, start_q, start_d, nf_q, nf_d;
  logic              op_q, op_d;
  fit_e              pol_q, pol_d;
  logic [NEED_W-1:0] need_q, need_d;
  logic [ADDR_W-1:0] fbase_q, fbase_d;
  logic              hb_q, hb_d;
  logic [IDX_W-1:0]  bi_q, bi_d;
  logic [ADDR_W-1:0] bb_q, bb_d;
  logic [SIZE_W-1:0] bs_q, bs_d;
  logic              lo_q, lo_d, up_q, up_d, fr_q, fr_d;
  logic [IDX_W-1:0]  lo_i_q, lo_i_d, up_i_q, up_i_d, fr_i_q, fr_i_d;
  logic [ADDR_W-1:0] lo_b_q, lo_b_d;
  logic [SIZE_W-1:0] lo_s_q, lo_s_d, up_s_q, up_s_d;
  logic              rv_q, rv_d, rok_q, rok_d;
  logic [ADDR_W-1:0] rbase_q, rbase_d;

  logic              first_type;
  logic [NEED_W-1:0] fend;
  logic [SIZE_W-1:0] ent_end;
  logic              free_bad;

  assign rd_idx     = start_q + cnt_q;
  assign first_type = (pol_q == FIT_FIRST) || (pol_q == FIT_NEXT);
  assign fend       = NEED_W'(fbase_q) + need_q;
  assign ent_end    = {1'b0, rd_base} + rd_size;
  assign free_bad   = (need_q == '0) || (fend > MEM_END);

  assign cmp_policy = pol_q;
  assign cmp_need   = need_q;
  assign cmp_have   = hb_q;
  assign cmp_bbase  = bb_q;
  assign cmp_bsize  = bs_q;

  always_comb begin
    st_d = st_q;   cnt_d = cnt_q;   start_d = start_q; nf_d = nf_q;
    op_d = op_q;   pol_d = pol_q;   need_d = need_q;   fbase_d = fbase_q;
    hb_d = hb_q;   bi_d = bi_q;     bb_d = bb_q;       bs_d = bs_q;
    lo_d = lo_q;   lo_i_d = lo_i_q; lo_b_d = lo_b_q;   lo_s_d = lo_s_q;
    up_d = up_q;   up_i_d = up_i_q; up_s_d = up_s_q;
    fr_d = fr_q;   fr_i_d = fr_i_q;
    rv_d = 1'b0;   rok_d = rok_q;   rbase_d = rbase_q;
    wa_en = 1'b0;  wa_idx = '0; wa_vld = 1'b0; wa_base = '0; wa_size = '0;
    wb_en = 1'b0;  wb_idx = '0;

    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          op_d    = req_op;
          pol_d   = fit_e'(req_fit);
          need_d  = ({1'b0, req_size} + BLK_MASK) & ~BLK_MASK;
          fbase_d = req_base;
          start_d = (req_op == OP_ALLOC && fit_e'(req_fit) == FIT_NEXT) ? nf_q : '0;
          cnt_d   = '0;
          hb_d = 1'b0; lo_d = 1'b0; up_d = 1'b0; fr_d = 1'b0;
          st_d    = ST_SCAN;
        end
      end
      ST_SCAN: begin
        cnt_d = cnt_q + 1'b1;
        if (op_q == OP_ALLOC) begin
          if (better) begin
            hb_d = 1'b1; bi_d = rd_idx; bb_d = rd_base; bs_d = rd_size;
          end
          if ((first_type && fits) || cnt_q == LAST) st_d = ST_COMMIT;
        end else begin
          if (!lo_q && rd_vld && ent_end == {1'b0, fbase_q}) begin
            lo_d = 1'b1; lo_i_d = rd_idx; lo_b_d = rd_base; lo_s_d = rd_size;
          end
          if (!up_q && rd_vld && NEED_W'(rd_base) == fend) begin
            up_d = 1'b1; up_i_d = rd_idx; up_s_d = rd_size;
          end
          if (!fr_q && !rd_vld) begin
            fr_d = 1'b1; fr_i_d = rd_idx;
          end
          if (cnt_q == LAST) st_d = ST_COMMIT;
        end
      end
      ST_COMMIT: begin
        rv_d    = 1'b1;
        rok_d   = 1'b0;
        rbase_d = '0;
        st_d    = ST_IDLE;
        if (op_q == OP_ALLOC) begin
          if (hb_q) begin
            wa_en   = 1'b1;
            wa_idx  = bi_q;
            wa_base = bb_q + need_q[ADDR_W-1:0];
            wa_size = bs_q - need_q[SIZE_W-1:0];
            wa_vld  = bs_q != need_q[SIZE_W-1:0];
            rok_d   = 1'b1;
            rbase_d = bb_q;
            if (first_type) nf_d = bi_q;
          end
        end else if (!free_bad) begin
          if (lo_q && up_q) begin
            wa_en = 1'b1; wa_idx = lo_i_q; wa_vld = 1'b1; wa_base = lo_b_q;
            wa_size = lo_s_q + need_q[SIZE_W-1:0] + up_s_q;
            wb_en = 1'b1; wb_idx = up_i_q;
            rok_d = 1'b1;
          end else if (lo_q) begin
            wa_en = 1'b1; wa_idx = lo_i_q; wa_vld = 1'b1; wa_base = lo_b_q;
            wa_size = lo_s_q + need_q[SIZE_W-1:0];
            rok_d = 1'b1;
          end else if (up_q) begin
            wa_en = 1'b1; wa_idx = up_i_q; wa_vld = 1'b1; wa_base = fbase_q;
            wa_size = up_s_q + need_q[SIZE_W-1:0];
            rok_d = 1'b1;
          end else if (fr_q) begin
            wa_en = 1'b1; wa_idx = fr_i_q; wa_vld = 1'b1; wa_base = fbase_q;
            wa_size = need_q[SIZE_W-1:0];
            rok_d = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; start_q <= '0; nf_q <= '0;
      op_q <= OP_ALLOC; pol_q <= FIT_FIRST; need_q <= '0; fbase_q <= '0;
      hb_q <= 1'b0; bi_q <= '0; bb_q <= '0; bs_q <= '0;
      lo_q <= 1'b0; lo_i_q <= '0; lo_b_q <= '0; lo_s_q <= '0;
      up_q <= 1'b0; up_i_q <= '0; up_s_q <= '0;
      fr_q <= 1'b0; fr_i_q <= '0;
      rv_q <= 1'b0; rok_q <= 1'b0; rbase_q <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; start_q <= start_d; nf_q <= nf_d;
      op_q <= op_d; pol_q <= pol_d; need_q <= need_d; fbase_q <= fbase_d;
      hb_q <= hb_d; bi_q <= bi_d; bb_q <= bb_d; bs_q <= bs_d;
      lo_q <= lo_d; lo_i_q <= lo_i_d; lo_b_q <= lo_b_d; lo_s_q <= lo_s_d;
      up_q <= up_d; up_i_q <= up_i_d; up_s_q <= up_s_d;
      fr_q <= fr_d; fr_i_q <= fr_i_d;
      rv_q <= rv_d; rok_q <= rok_d; rbase_q <= rbase_d;
    end
  end

  assign busy      = st_q != ST_IDLE;
  assign rsp_valid = rv_q;
  assign rsp_ok    = rok_q;
  assign rsp_base  = rbase_q;
endmodule

// File: rtl/hole_alloc.sv
module hole_alloc
  import hole_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 12,
  parameter int BLK_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [1:0]        req_fit,
  input  logic [ADDR_W:0]   req_size,
  input  logic [ADDR_W-1:0] req_base,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [ADDR_W-1:0] rsp_base
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int SIZE_W = ADDR_W + 1;
  localparam int NEED_W = SIZE_W + 1;

  logic              rst_sync_n;
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_vld;
  logic [ADDR_W-1:0] rd_base;
  logic [SIZE_W-1:0] rd_size;
  logic              fits, better;
  fit_e              cmp_policy;
  logic [NEED_W-1:0] cmp_need;
  logic              cmp_have;
  logic [ADDR_W-1:0] cmp_bbase;
  logic [SIZE_W-1:0] cmp_bsize;
  logic              wa_en, wa_vld, wb_en;
  logic [IDX_W-1:0]  wa_idx, wb_idx;
  logic [ADDR_W-1:0] wa_base;
  logic [SIZE_W-1:0] wa_size;

  hole_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  hole_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_table (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_base(rd_base), .rd_size(rd_size),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_vld(wa_vld), .wa_base(wa_base), .wa_size(wa_size),
    .wb_en(wb_en), .wb_idx(wb_idx)
  );

  hole_fit_cmp #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .NEED_W(NEED_W)) u_cmp (
    .policy(cmp_policy), .ent_vld(rd_vld), .ent_base(rd_base), .ent_size(rd_size),
    .need(cmp_need), .have_best(cmp_have), .best_base(cmp_bbase), .best_size(cmp_bsize),
    .fits(fits), .better(better)
  );

  hole_ctrl #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .BLK_W(BLK_W), .IDX_W(IDX_W),
              .SIZE_W(SIZE_W), .NEED_W(NEED_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .req_valid(req_valid), .req_op(req_op), .req_fit(req_fit),
    .req_size(req_size), .req_base(req_base),
    .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_base(rd_base), .rd_size(rd_size),
    .fits(fits), .better(better),
    .cmp_policy(cmp_policy), .cmp_need(cmp_need), .cmp_have(cmp_have),
    .cmp_bbase(cmp_bbase), .cmp_bsize(cmp_bsize),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_vld(wa_vld), .wa_base(wa_base), .wa_size(wa_size),
    .wb_en(wb_en), .wb_idx(wb_idx),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_base(rsp_base)
  );
endmodule

// File: rtl/hole_alloc_chk.sv
module hole_alloc_chk #(
  parameter int ADDR_W = 12,
  parameter int BLK_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic [ADDR_W-1:0] rsp_base
);
  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_end_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);

  p_rsp_from_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(busy) && !busy));

  p_grant_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok) |-> (rsp_base[BLK_W-1:0] == '0));

  p_fail_base_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> (rsp_base == '0));
endmodule

bind hole_alloc hole_alloc_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_base(rsp_base)
);

// File: tb/hole_alloc_bench.sv
`timescale 1ns/1ps
module hole_alloc_bench;
  localparam int ENTRIES = 8;
  localparam int ADDR_W  = 12;
  localparam int BLK     = 16;
  localparam int MEM     = 4096;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_op;
  logic [1:0]        req_fit;
  logic [ADDR_W:0]   req_size;
  logic [ADDR_W-1:0] req_base;
  logic              busy, rsp_valid, rsp_ok;
  logic [ADDR_W-1:0] rsp_base;

  hole_alloc #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .BLK_W(4)) u_hole_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_fit(req_fit),
    .req_size(req_size), .req_base(req_base), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_base(rsp_base)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      n_err = n_err + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // reference table
  bit mv [ENTRIES];
  int mb [ENTRIES];
  int ms [ENTRIES];
  int mptr;
  logic [31:0] xs;

  function automatic int rnd(int n);
    xs = xs ^ (xs << 13);
    xs = xs ^ (xs >> 17);
    xs = xs ^ (xs << 5);
    return int'(xs % 32'(n));
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_err = n_err + 1;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < ENTRIES; i++) begin
      mv[i] = 1'b0; mb[i] = 0; ms[i] = 0;
    end
    mv[0] = 1'b1; ms[0] = MEM; mptr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    req_valid = 1'b0; req_op = 1'b0; req_fit = 2'd0; req_size = '0; req_base = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  task automatic m_alloc(int size, int fit, output int ok, output int base, output int lat);
    int need;
    int sel;
    int st;
    need = ((size + BLK - 1) / BLK) * BLK;
    sel = -1;
    lat = ENTRIES + 1;
    if (need > 0) begin
      if (fit == 0 || fit == 3) begin
        st = (fit == 3) ? mptr : 0;
        for (int j = 0; j < ENTRIES; j++) begin
          int i;
          i = (st + j) % ENTRIES;
          if (mv[i] && ms[i] >= need) begin
            sel = i; lat = j + 2;
            break;
          end
        end
      end else begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (mv[i] && ms[i] >= need) begin
            if (sel < 0) sel = i;
            else if (fit == 1) begin
              if (ms[i] < ms[sel] || (ms[i] == ms[sel] && mb[i] < mb[sel])) sel = i;
            end else begin
              if (ms[i] > ms[sel] || (ms[i] == ms[sel] && mb[i] < mb[sel])) sel = i;
            end
          end
        end
      end
    end
    if (sel >= 0) begin
      ok = 1; base = mb[sel];
      mb[sel] = mb[sel] + need; ms[sel] = ms[sel] - need; mv[sel] = (ms[sel] != 0);
      if (fit == 0 || fit == 3) mptr = sel;
    end else begin
      ok = 0; base = 0;
    end
  endtask

  task automatic m_free(int base, int size, output int ok, output int lat);
    int need, lo, up, fr;
    need = ((size + BLK - 1) / BLK) * BLK;
    lat = ENTRIES + 1;
    ok = 0;
    if (need > 0 && base + need <= MEM) begin
      lo = -1; up = -1; fr = -1;
      for (int i = 0; i < ENTRIES; i++) begin
        if (mv[i] && mb[i] + ms[i] == base && lo < 0) lo = i;
        if (mv[i] && mb[i] == base + need && up < 0) up = i;
        if (!mv[i] && fr < 0) fr = i;
      end
      if (lo >= 0 && up >= 0) begin
        ms[lo] = ms[lo] + need + ms[up]; mv[up] = 1'b0; ok = 1;
      end else if (lo >= 0) begin
        ms[lo] = ms[lo] + need; ok = 1;
      end else if (up >= 0) begin
        mb[up] = base; ms[up] = ms[up] + need; ok = 1;
      end else if (fr >= 0) begin
        mv[fr] = 1'b1; mb[fr] = base; ms[fr] = need; ok = 1;
      end
    end
  endtask

  task automatic issue(bit op, int fit, int size, int base, bit junk,
                       output int ok, output int rbase, output int lat);
    @(negedge clk);
    req_op = op; req_fit = 2'(fit); req_size = (ADDR_W+1)'(size);
    req_base = ADDR_W'(base); req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11", int'(busy), 1, "busy after accept");
    if (junk) begin
      req_op = 1'b1; req_fit = 2'd0; req_size = 13'd64; req_base = 12'd0; req_valid = 1'b1;
    end
    lat = 0;
    while (!rsp_valid && lat < 100) begin
      @(posedge clk);
      lat = lat + 1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    ok = int'(rsp_ok);
    rbase = int'(rsp_base);
    chk("R11", int'(busy), 0, "busy with response");
    @(negedge clk);
    chk("R11", int'(rsp_valid), 0, "response pulse width");
  endtask

  task automatic t_alloc(int size, int fit, string tag, bit junk, output int gok, output int gbase);
    int eok, ebase, elat, alat;
    m_alloc(size, fit, eok, ebase, elat);
    issue(1'b0, fit, size, 0, junk, gok, gbase, alat);
    chk(tag, gok, eok, "alloc ok");
    if (eok == 1) chk(tag, gbase, ebase, "alloc base");
    else          chk("R8", gbase, 0, "failed alloc base");
    chk(tag, alat, elat, "alloc latency");
  endtask

  task automatic t_free(int base, int size, string tag, bit junk, output int gok);
    int eok, elat, alat, abase;
    m_free(base, size, eok, elat);
    issue(1'b1, 0, size, base, junk, gok, abase, alat);
    chk(tag, gok, eok, "free ok");
    chk(tag, alat, elat, "free latency");
  endtask

  function automatic string fit_tag(int fit);
    case (fit)
      0: return "R3";
      1: return "R5";
      2: return "R6";
      default: return "R4";
    endcase
  endfunction

  int lb [32];
  int lsz [32];
  int nlive;

  initial begin
    int ok, b;
    xs = 32'h1234_5679;
    rst_n = 1'b0;
    req_valid = 1'b0; req_op = 1'b0; req_fit = 2'd0; req_size = '0; req_base = '0;
    do_reset();

    // R1: reset state and single full-size hole
    chk("R1", int'(busy), 0, "busy at reset");
    chk("R1", int'(rsp_valid), 0, "rsp_valid at reset");
    t_alloc(4096, 2, "R1", 1'b0, ok, b);
    t_alloc(16, 0, "R8", 1'b0, ok, b);
    t_free(0, 4096, "R10", 1'b0, ok);

    // R2: rounding and zero-size cases
    t_alloc(0, 0, "R2", 1'b0, ok, b);
    t_alloc(1, 0, "R2", 1'b0, ok, b);
    t_alloc(17, 0, "R2", 1'b1, ok, b);
    t_alloc(16, 0, "R2", 1'b0, ok, b);
    t_free(100, 0, "R2", 1'b0, ok);
    t_free(4090, 16, "R2", 1'b0, ok);

    // R5 tie, R9 merges, R7 exact consumption
    do_reset();
    t_alloc(32, 0, "R3", 1'b0, ok, b);
    t_alloc(16, 0, "R3", 1'b0, ok, b);
    t_alloc(32, 0, "R3", 1'b0, ok, b);
    t_alloc(16, 0, "R3", 1'b0, ok, b);
    t_free(48, 32, "R10", 1'b0, ok);
    t_free(0, 32, "R10", 1'b1, ok);
    t_alloc(20, 1, "R5", 1'b0, ok, b);
    t_free(0, 32, "R10", 1'b0, ok);
    t_free(32, 16, "R9", 1'b0, ok);
    t_alloc(80, 1, "R7", 1'b0, ok, b);
    t_alloc(70, 2, "R6", 1'b0, ok, b);
    t_free(80, 16, "R9", 1'b0, ok);
    t_free(0, 80, "R9", 1'b0, ok);
    t_alloc(4000, 3, "R4", 1'b0, ok, b);
    t_alloc(30, 3, "R4", 1'b1, ok, b);

    // R10 table overflow, R8 fragmented failure
    do_reset();
    for (int k = 0; k < 16; k++) t_alloc(16, 0, "R3", 1'b0, ok, b);
    for (int k = 0; k < 7; k++) t_free(k * 32, 16, "R10", 1'b0, ok);
    t_free(224, 16, "R10", 1'b1, ok);
    t_free(240, 16, "R9", 1'b0, ok);
    t_alloc(4000, 1, "R8", 1'b0, ok, b);
    t_alloc(32, 3, "R4", 1'b0, ok, b);
    t_alloc(16, 3, "R4", 1'b0, ok, b);
    t_alloc(16, 2, "R6", 1'b0, ok, b);

    // sweep across policies and sizes
    do_reset();
    nlive = 0;
    for (int it = 0; it < 500; it++) begin
      if (nlive > 0 && (rnd(3) == 0 || nlive == 32)) begin
        int k;
        k = rnd(nlive);
        t_free(lb[k], lsz[k], "R9", 1'b0, ok);
        if (ok == 1) begin
          lb[k] = lb[nlive-1]; lsz[k] = lsz[nlive-1]; nlive = nlive - 1;
        end
      end else begin
        int sz, ft;
        sz = 1 + rnd(700);
        ft = rnd(4);
        t_alloc(sz, ft, fit_tag(ft), 1'b0, ok, b);
        if (ok == 1) begin
          lb[nlive] = b; lsz[nlive] = sz; nlive = nlive + 1;
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule